// File: doc/BRIEF.md
# ADC Conversion Clock Prescaler

This block holds one 8-bit bus-writable configuration register and turns one of two incoming clock-enable strobes into the conversion clock enable for an analog-to-digital converter. One field of the register picks the source: the internal bus clock strobe or the external oscillator strobe. A second field picks a power-of-two divide ratio from 1 to 16. Both sources are enable pulses in the single system clock domain. The divided result leaves the block as a one-cycle strobe.

Changing the conversion clock while a conversion is running spoils that conversion. The block therefore watches a busy input from the converter. Any register write that lands while busy is high sets a sticky error flag. The flag stays set until a dedicated clear strobe or reset.

Top module: `adc_clk_prescaler`

## Requirements
- R1: After reset the register reads 0x00, the external strobe is the source at divide-by-1, and the error flag is 0.
- R2: The divide code sits in write/read bits 7:5 and the source bit in bit 4. Bits 3:0 always read 0, whatever value was written.
- R3: Divide codes 000, 001, 010 and 011 give one output strobe per 1, 2, 4 and 8 strobes of the selected source.
- R4: Any divide code with bit 7 set (1xx) gives one output strobe per 16 source strobes; bits 6:5 are then ignored.
- R5: A source bit of 1 selects the bus clock strobe. A source bit of 0 selects the external strobe.
- R6: The register loads only when the write enable is high and the address equals REG_ADDR. A read at any other address returns 0.
- R7: A write that changes the divide code or the source bit restarts the divider. The first output strobe then comes exactly one full new period of source strobes after the write edge, and no strobe is issued at the write edge.
- R8: Each output strobe lasts one cycle. It appears one clock after the source strobe that completes a period, and this delay is the same in every mode.
- R9: A register write while the busy input is high sets the error flag on the next clock.
- R10: The error flag holds until the clear input is pulsed or reset is applied. A write with busy low does not set it, and a simultaneous set wins over clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | Bus clock enable strobe |
| ext_tick | input | 1 | External oscillator enable strobe |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Read data (0 when the address does not match) |
| conv_busy | input | 1 | Converter busy indication |
| err_clr | input | 1 | Clears the error flag |
| conv_tick | output | 1 | Divided conversion clock enable |
| cfg_err | output | 1 | Sticky write-during-conversion flag |

## Verification
The hardest case to reach from the ports is the restart phase. The first strobe after a reconfiguration must come a full period later, however far the old count had advanced. To get there, the stimulus table writes a new configuration directly over the previous one with no wait for alignment. A directed test also rewrites the divider three cycles into a divide-by-8 period. Both measure the cycles up to the first strobe. With the external source, the strobe arrives every third cycle, so the period gap reflects the source choice and the latency test reflects the restart.

// File: rtl/adc_pre_pkg.sv
package adc_pre_pkg;

  localparam int REG_W   = 8;
  localparam int CODE_W  = 3;
  localparam int SHIFT_W = 3;
  localparam int MAX_SHIFT = 4;

  typedef struct packed {
    logic [CODE_W-1:0] div_code;
    logic              src_bus;
  } pre_cfg_t;

  // Maps the divide code to log2 of the divisor; top bit forces 16.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    if (code[CODE_W-1]) s = SHIFT_W'(MAX_SHIFT);
    else                s = SHIFT_W'(code[1:0]);
    return s;
  endfunction

endpackage

// File: rtl/adc_pre_reg.sv
module adc_pre_reg
  import adc_pre_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output pre_cfg_t          cfg,
  output logic              wr_hit,
  output logic              cfg_change,
  output logic [REG_W-1:0]  rdata
);

  localparam int PAD_W = REG_W - CODE_W - 1;

  pre_cfg_t cfg_q, cfg_d;
  logic     addr_hit;

  assign addr_hit = (addr == REG_ADDR);
  assign wr_hit   = wr_en && addr_hit;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_hit) begin
      cfg_d.div_code = wdata[REG_W-1 -: CODE_W];
      cfg_d.src_bus  = wdata[PAD_W];
    end
  end

  assign cfg_change = wr_hit && (cfg_d != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg   = cfg_q;
  assign rdata = addr_hit ? {cfg_q.div_code, cfg_q.src_bus, {PAD_W{1'b0}}} : '0;

endmodule

// File: rtl/adc_pre_div.sv
module adc_pre_div
  import adc_pre_pkg::*;
#(
  parameter int CNT_W = MAX_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               restart,
  output logic               strobe_out
);

  logic [CNT_W-1:0] cnt_q, cnt_d, term;
  logic             stb_q, stb_d, at_term;

  assign term    = ~({CNT_W{1'b1}} << shift);
  assign at_term = (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    stb_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (tick_in) begin
      stb_d = at_term;
      cnt_d = at_term ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign strobe_out = stb_q;

endmodule

// File: rtl/adc_pre_err.sv
module adc_pre_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
  import adc_pre_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_tick,
  input  logic              ext_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              conv_busy,
  input  logic              err_clr,
  output logic              conv_tick,
  output logic              cfg_err
);

  pre_cfg_t           cfg;
  logic               wr_hit, cfg_change, src_tick;
  logic [SHIFT_W-1:0] shift;

  adc_pre_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg(cfg), .wr_hit(wr_hit), .cfg_change(cfg_change), .rdata(rdata)
  );

  assign src_tick = cfg.src_bus ? bus_tick : ext_tick;
  assign shift    = code_to_shift(cfg.div_code);

  adc_pre_div #(.CNT_W(MAX_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(src_tick), .shift(shift),
    .restart(cfg_change), .strobe_out(conv_tick)
  );

  adc_pre_err u_err (
    .clk(clk), .rst_n(rst_n), .set_i(wr_hit && conv_busy),
    .clr_i(err_clr), .flag_o(cfg_err)
  );

endmodule

// File: rtl/adc_pre_checker.sv
module adc_pre_checker #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_tick,
  input logic              ext_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              conv_busy,
  input logic              err_clr,
  input logic              conv_tick,
  input logic              cfg_err
);

  logic hit_wr;
  assign hit_wr = wr_en && (addr == REG_ADDR);

  a_r9_err_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && conv_busy) |=> cfg_err);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !err_clr) |=> cfg_err);

  a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(hit_wr && conv_busy)) |=> !cfg_err);

  a_r7_no_tick_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && (wdata[7:4] != rdata[7:4])) |=> !conv_tick);

  a_r8_tick_follows_source: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick |-> $past(bus_tick || ext_tick));

endmodule

bind adc_clk_prescaler adc_pre_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .ext_tick(ext_tick),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .conv_busy(conv_busy), .err_clr(err_clr), .conv_tick(conv_tick), .cfg_err(cfg_err)
);

// File: tb/sim_adc_clk_prescaler.sv
`timescale 1ns/1ps
module sim_adc_clk_prescaler;

  localparam logic [7:0] RADDR = 8'h40;
  localparam int NV = 9;
  // write value, expected period in cycles, latency checked (bus source)
  localparam logic [7:0] VEC_WD  [NV] = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hF0, 8'h20, 8'h60, 8'hA0};
  localparam int         VEC_PER [NV] = '{1, 2, 4, 8, 16, 16, 6, 24, 48};
  localparam bit         VEC_LAT [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 0};

  logic clk = 0, rst_n = 0;
  logic bus_tick = 1, ext_tick = 0;
  logic wr_en = 0, conv_busy = 0, err_clr = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic conv_tick, cfg_err;
  int checks = 0, errs = 0, cyc = 0, ext_cnt = 0;

  always #2 clk = ~clk;

  adc_clk_prescaler #(.ADDR_W(8), .REG_ADDR(RADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .ext_tick(ext_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .conv_busy(conv_busy), .err_clr(err_clr), .conv_tick(conv_tick), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    ext_cnt  <= (ext_cnt == 2) ? 0 : ext_cnt + 1;
    ext_tick <= (ext_cnt == 2);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic busy);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; conv_busy = busy;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; conv_busy = 0; addr = RADDR;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata; addr = RADDR;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); n++;
      if (conv_tick) break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int lat, per, n;
    repeat (3) @(negedge clk);
    rd(RADDR, v);                chk("R1 reset value", v, 0);
    chk("R1 error flag", cfg_err, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: external source, divide-by-1: every ext strobe (period 3)
    wait_tick(n); wait_tick(per); chk("R1 default period", per, 3);

    // stimulus table: R3 / R4 / R5 / R7 / R8
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = VEC_WD[i][7] ? "R4" : (VEC_WD[i][4] ? "R3" : "R5");
      wr(RADDR, VEC_WD[i], 0);
      wait_tick(lat);
      if (VEC_LAT[i]) chk("R7 first strobe latency", lat, VEC_PER[i]);
      wait_tick(per);
      chk(tag, per, VEC_PER[i]);
      if (VEC_PER[i] > 1) begin
        @(negedge clk); chk("R8 one-cycle strobe", conv_tick, 0);
      end
    end

    // R2: pad bits read 0
    wr(RADDR, 8'hFF, 0);
    rd(RADDR, v); chk("R2 pad bits", v, 8'hF0);

    // R6: foreign write ignored, foreign read 0
    wr(8'h41, 8'h30, 0);
    rd(RADDR, v); chk("R6 foreign write ignored", v, 8'hF0);
    rd(8'h41, v); chk("R6 foreign read", v, 0);

    // R7: rewrite mid-period of divide-by-8
    wr(RADDR, 8'h70, 0);
    repeat (3) @(negedge clk);
    wr(RADDR, 8'h50, 0);
    wait_tick(lat); chk("R7 mid-period restart", lat, 4);

    // R9 / R10
    wr(RADDR, 8'h50, 1); chk("R9 busy write sets", cfg_err, 1);
    wr(RADDR, 8'h30, 0); chk("R10 sticky", cfg_err, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R10 clear strobe", cfg_err, 0);
    wr(RADDR, 8'h10, 0); chk("R10 idle write no set", cfg_err, 0);
    wr(8'h41, 8'h10, 1); chk("R9 foreign busy write", cfg_err, 0);
    wr(RADDR, 8'h20, 1);
    @(negedge clk); rst_n = 0; #0.5;
    chk("R10 reset clears", cfg_err, 0);
    rd(RADDR, v); chk("R1 reset reloads", v, 0);
    @(negedge clk); rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule